// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, given as a segment number plus an offset, into a physical address. It first compares the segment number against a table-length register. If the number is in range, it reads that segment's descriptor from memory at an address derived from a table-base register. The descriptor supplies the segment's starting physical address, its length, a present flag and three access-right bits. The block then checks the requested access and the offset against that descriptor. It answers with either the physical address or a two-bit fault code.

Only one translation is in flight at a time. A privileged configuration port loads the two table registers. A write that arrives while a translation is open is parked and applied once that translation has answered, so each translation sees the register values it was accepted with. Descriptor reads use a valid/ready request channel and a separate one-cycle data return.

Top module: `seg_xlate`

## Requirements
- R1: After reset the table-base and table-length registers are zero, req_ready is high, and rsp_valid and mem_req_valid are low. Any request made before the length register is written answers with fault 2'b01.
- R2: A request is taken when req_valid and req_ready are both high. req_ready is high only while no translation is open. Each answer is a one-cycle rsp_valid pulse, and req_ready is high again in the following cycle.
- R3: When the segment number is not below the table-length register, the answer is fault 2'b01. It comes in the cycle right after acceptance, and no descriptor read is issued.
- R4: Otherwise a descriptor read is requested at address (table base + segment number) modulo 2^MA_W. mem_req_valid and mem_req_addr stay steady until mem_req_ready is seen high.
- R5: The descriptor word holds these fields: bit 0 is the present flag; bit 1 allows reads, bit 2 allows writes and bit 3 allows execution; bits [4 +: OFF_W+1] hold the segment length; bits [OFF_W+5 +: PA_W] hold the segment's base physical address.
- R6: A descriptor whose present flag is 0 gives fault 2'b10, whatever its other fields hold.
- R7: Access type 2'b00 (read) needs descriptor bit 1, 2'b01 (write) needs bit 2 and 2'b10 (execute) needs bit 3. Type 2'b11 is never allowed. A missing right gives fault 2'b11.
- R8: An offset equal to or greater than the descriptor's length gives fault 2'b11.
- R9: A successful translation answers fault 2'b00 with rsp_paddr = (descriptor base + offset) modulo 2^PA_W. Every faulting answer carries rsp_paddr = 0.
- R10: For an in-range segment, rsp_valid rises in the cycle right after the cycle in which mem_rsp_valid is high.
- R11: cfg_sel 0 selects the table base (all MA_W bits of cfg_wdata), and cfg_sel 1 selects the table length (low SEG_W+1 bits). A write made while no translation is open takes effect at the next clock edge. A write made while a translation is open is held and applied at the edge that ends that translation's answer, with the last write to each register winning. A translation always uses the register values present when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table length |
| cfg_wdata | input | MA_W | Configuration write value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| rsp_valid | output | 1 | One-cycle answer strobe |
| rsp_fault | output | 2 | 00 ok, 01 segment out of range, 10 descriptor not present, 11 rights or length violation |
| rsp_paddr | output | PA_W | Physical address, zero on a fault |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | MA_W | Descriptor word address |
| mem_rsp_valid | input | 1 | Descriptor data present |
| mem_rsp_data | input | OFF_W+PA_W+5 | Descriptor word |

## Verification
The hardest case to reach from the ports is a configuration write that lands while a translation is still open. It is the only time the parked-write path is used. The bench makes it happen by holding the memory's request ready low, so the translation stays in its fetch phase. While it is held there, the bench writes the base twice and then the length. It then checks that the held translation read its descriptor at the old address, that the next one uses the last base written, and that a segment beyond the new length faults. The rest of the bench sweeps every segment, offset and access type in a small configuration against descriptors built arithmetically, including a base that wraps the address space.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'b00,
      FLT_RANGE   = 2'b01,
      FLT_ABSENT  = 2'b10,
      FLT_ACCESS  = 2'b11
   } flt_e;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_RESP
   } st_e;

   localparam int unsigned DESC_FLAG_W = 4;

endpackage

// File: rtl/seg_cfg_regs.sv
`timescale 1ns/1ps
module seg_cfg_regs #(
   parameter int unsigned MA_W  = 12,
   parameter int unsigned LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [MA_W-1:0]  wr_data,
   input  logic             busy,
   input  logic             commit,
   output logic [MA_W-1:0]  base_q,
   output logic [LEN_W-1:0] len_q
);

   logic             pend_base_v;
   logic             pend_len_v;
   logic [MA_W-1:0]  pend_base;
   logic [LEN_W-1:0] pend_len;
   logic             wr_base;
   logic             wr_len;

   assign wr_base = wr_en && !wr_sel;
   assign wr_len  = wr_en &&  wr_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q      <= '0;
         len_q       <= '0;
         pend_base   <= '0;
         pend_len    <= '0;
         pend_base_v <= 1'b0;
         pend_len_v  <= 1'b0;
      end else if (!busy) begin
         if (wr_base) base_q <= wr_data;
         if (wr_len)  len_q  <= wr_data[LEN_W-1:0];
      end else if (commit) begin
         if (wr_base)          base_q <= wr_data;
         else if (pend_base_v) base_q <= pend_base;
         if (wr_len)           len_q  <= wr_data[LEN_W-1:0];
         else if (pend_len_v)  len_q  <= pend_len;
         pend_base_v <= 1'b0;
         pend_len_v  <= 1'b0;
      end else begin
         if (wr_base) begin
            pend_base   <= wr_data;
            pend_base_v <= 1'b1;
         end
         if (wr_len) begin
            pend_len    <= wr_data[LEN_W-1:0];
            pend_len_v  <= 1'b1;
         end
      end
   end

   p_idle_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_base) |=> (base_q == $past(wr_data)));

   p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !commit) |=> ($stable(base_q) && $stable(len_q)));

endmodule

// File: rtl/seg_desc_check.sv
`timescale 1ns/1ps
module seg_desc_check
   import seg_xlate_pkg::*;
#(
   parameter int unsigned OFF_W  = 10,
   parameter int unsigned PA_W   = 16,
   parameter int unsigned LIM_W  = OFF_W + 1,
   parameter int unsigned DESC_W = DESC_FLAG_W + LIM_W + PA_W
) (
   input  logic [DESC_W-1:0] desc,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        acc,
   output logic [1:0]        fault,
   output logic [PA_W-1:0]   paddr
);

   localparam int unsigned LIM_LSB  = DESC_FLAG_W;
   localparam int unsigned BASE_LSB = DESC_FLAG_W + LIM_W;

   logic              present;
   logic [2:0]        rights;
   logic [LIM_W-1:0]  seg_len;
   logic [PA_W-1:0]   seg_base;
   logic [PA_W-1:0]   off_pa;
   logic              allowed;
   logic              in_bound;
   flt_e              flt;

   assign present  = desc[0];
   assign rights   = desc[3:1];
   assign seg_len  = desc[LIM_LSB +: LIM_W];
   assign seg_base = desc[BASE_LSB +: PA_W];

   generate
      if (OFF_W >= PA_W) begin : g_off_trunc
         assign off_pa = off[PA_W-1:0];
      end else begin : g_off_ext
         assign off_pa = {{(PA_W-OFF_W){1'b0}}, off};
      end
   endgenerate

   always_comb begin
      unique case (acc_e'(acc))
         ACC_LOAD:  allowed = rights[0];
         ACC_STORE: allowed = rights[1];
         ACC_EXEC:  allowed = rights[2];
         default:   allowed = 1'b0;
      endcase
   end

   assign in_bound = {1'b0, off} < seg_len;

   always_comb begin
      if (!present)                  flt = FLT_ABSENT;
      else if (!allowed || !in_bound) flt = FLT_ACCESS;
      else                           flt = FLT_NONE;
   end

   assign fault = flt;
   assign paddr = (flt == FLT_NONE) ? (seg_base + off_pa) : '0;

endmodule

// File: rtl/seg_xlate.sv
`timescale 1ns/1ps
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int unsigned SEG_W = 4,
   parameter int unsigned OFF_W = 10,
   parameter int unsigned PA_W  = 16,
   parameter int unsigned MA_W  = 12,
   localparam int unsigned LEN_W  = SEG_W + 1,
   localparam int unsigned LIM_W  = OFF_W + 1,
   localparam int unsigned DESC_W = DESC_FLAG_W + LIM_W + PA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [MA_W-1:0]   cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [1:0]        req_acc,
   output logic              rsp_valid,
   output logic [1:0]        rsp_fault,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [MA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DESC_W-1:0] mem_rsp_data
);

   generate
      if (SEG_W < 1 || OFF_W < 1 || PA_W < 1) begin : g_bad_width
         $error("seg_xlate: SEG_W, OFF_W and PA_W must be at least 1");
      end
      if (MA_W < LEN_W) begin : g_bad_ma
         $error("seg_xlate: MA_W must cover the table-length register");
      end
   endgenerate

   st_e               state;
   logic [OFF_W-1:0]  off_q;
   logic [1:0]        acc_q;
   logic [MA_W-1:0]   addr_q;
   logic [1:0]        fault_q;
   logic [PA_W-1:0]   paddr_q;
   logic [MA_W-1:0]   tbl_base;
   logic [LEN_W-1:0]  tbl_len;
   logic              accept;
   logic              in_range;
   logic              busy;
   logic              commit;
   logic [1:0]        chk_fault;
   logic [PA_W-1:0]   chk_paddr;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign in_range  = {1'b0, req_seg} < tbl_len;
   assign busy      = (state != ST_IDLE);
   assign commit    = (state == ST_RESP);

   seg_cfg_regs #(
      .MA_W  (MA_W),
      .LEN_W (LEN_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .busy    (busy),
      .commit  (commit),
      .base_q  (tbl_base),
      .len_q   (tbl_len)
   );

   seg_desc_check #(
      .OFF_W  (OFF_W),
      .PA_W   (PA_W),
      .LIM_W  (LIM_W),
      .DESC_W (DESC_W)
   ) u_chk (
      .desc  (mem_rsp_data),
      .off   (off_q),
      .acc   (acc_q),
      .fault (chk_fault),
      .paddr (chk_paddr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         off_q   <= '0;
         acc_q   <= '0;
         addr_q  <= '0;
         fault_q <= FLT_NONE;
         paddr_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  off_q  <= req_off;
                  acc_q  <= req_acc;
                  addr_q <= tbl_base + MA_W'(req_seg);
                  if (in_range) begin
                     state <= ST_FETCH;
                  end else begin
                     fault_q <= FLT_RANGE;
                     paddr_q <= '0;
                     state   <= ST_RESP;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  fault_q <= chk_fault;
                  paddr_q <= chk_paddr;
                  state   <= ST_RESP;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid     = (state == ST_RESP);
   assign rsp_fault     = fault_q;
   assign rsp_paddr     = paddr_q;
   assign mem_req_valid = (state == ST_FETCH);
   assign mem_req_addr  = addr_q;

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   p_fault_addr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

   p_rsp_after_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && state == ST_WAIT) |=> rsp_valid);

   p_range_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 2'b01) |-> $past(req_ready));

endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;

   localparam int SEG_W  = 3;
   localparam int OFF_W  = 4;
   localparam int PA_W   = 8;
   localparam int MA_W   = 6;
   localparam int LIM_W  = OFF_W + 1;
   localparam int DESC_W = 4 + LIM_W + PA_W;
   localparam int NMEM   = 1 << MA_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              cfg_we = 1'b0;
   logic              cfg_sel = 1'b0;
   logic [MA_W-1:0]   cfg_wdata = '0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [SEG_W-1:0]  req_seg = '0;
   logic [OFF_W-1:0]  req_off = '0;
   logic [1:0]        req_acc = '0;
   logic              rsp_valid;
   logic [1:0]        rsp_fault;
   logic [PA_W-1:0]   rsp_paddr;
   logic              mem_req_valid;
   logic              mem_req_ready = 1'b0;
   logic [MA_W-1:0]   mem_req_addr;
   logic              mem_rsp_valid = 1'b0;
   logic [DESC_W-1:0] mem_rsp_data = '0;

   seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .MA_W(MA_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   logic [DESC_W-1:0] mem [NMEM];
   int n_tests = 0;
   int n_fail  = 0;
   int hs_cnt  = 0;
   int cyc     = 0;
   int busy_cnt = 0;
   int last_addr = -1;
   int mdl_base = 0;
   int mdl_len  = 0;
   logic stall = 1'b0;
   logic [MA_W-1:0] a_l = '0;

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // descriptor memory model with variable ready and latency
   initial begin
      for (int i = 0; i < NMEM; i++) begin
         mem[i] = {PA_W'((i * 37 + 5) % 256), LIM_W'(i % 17),
                   3'((i * 5) % 8), (i % 7 != 3)};
      end
      forever begin
         @(negedge clk);
         cyc++;
         if (busy_cnt > 0) begin
            busy_cnt--;
            mem_rsp_valid = (busy_cnt == 0);
            if (busy_cnt == 0) mem_rsp_data = mem[a_l];
         end else begin
            mem_rsp_valid = 1'b0;
         end
         mem_req_ready = !stall && ((hs_cnt % 4 != 1) || cyc[0]);
         if (rst_n && mem_req_valid && mem_req_ready) begin
            a_l = mem_req_addr;
            last_addr = int'(mem_req_addr);
            busy_cnt = 1 + hs_cnt % 3;
            hs_cnt++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      summary();
   end

   task automatic cfg(input int sel, input int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel[0]; cfg_wdata = MA_W'(val);
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel == 0) mdl_base = val % NMEM; else mdl_len = val % 16;
   endtask

   task automatic model(input int s, input int o, input int a,
                        output int f, output int p, output int kind);
      logic [DESC_W-1:0] d;
      int lim;
      logic perm;
      p = 0; kind = 0;
      if (s >= mdl_len) begin f = 1; return; end
      d = mem[(mdl_base + s) % NMEM];
      lim = int'(d[4 +: LIM_W]);
      perm = (a < 3) ? d[1 + a] : 1'b0;
      if (!d[0]) f = 2;
      else if (!perm) begin f = 3; kind = 1; end
      else if (o >= lim) begin f = 3; kind = 2; end
      else begin f = 0; p = (int'(d[4 + LIM_W +: PA_W]) + o) % 256; end
   endtask

   task automatic xlate(input int s, input int o, input int a,
                        output int f, output int p, output int lat,
                        output int memseen, output int after_mem, output int pulse_ok);
      int prev;
      @(negedge clk);
      req_valid = 1'b1; req_seg = SEG_W'(s); req_off = OFF_W'(o); req_acc = 2'(a);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1; memseen = 0; prev = 0;
      while (!rsp_valid && lat < 60) begin
         if (mem_req_valid) memseen = 1;
         prev = int'(mem_rsp_valid);
         @(negedge clk);
         lat++;
      end
      after_mem = prev;
      f = int'(rsp_fault); p = int'(rsp_paddr);
      @(negedge clk);
      pulse_ok = int'(!rsp_valid && req_ready);
   endtask

   task automatic one(input int s, input int o, input int a);
      int f, p, lat, ms, am, pk, ef, ep, kind;
      model(s, o, a, ef, ep, kind);
      xlate(s, o, a, f, p, lat, ms, am, pk);
      chk("R2 answer pulse", pk, 1);
      if (ef == 1) begin
         chk("R3 range fault", f, 1);
         chk("R3 latency", lat, 1);
         chk("R3 no fetch", ms, 0);
         chk("R9 fault paddr", p, 0);
      end else begin
         chk("R4 descriptor addr", last_addr, (mdl_base + s) % NMEM);
         chk("R10 answer after data", am, 1);
         if (ef == 2) chk("R6 absent fault", f, 2);
         else if (kind == 1) chk("R7 rights fault", f, 3);
         else if (kind == 2) chk("R8 length fault", f, 3);
         else chk("R9 ok fault", f, 0);
         chk("R5 R9 paddr", p, ep);
      end
   endtask

   task automatic sweep();
      for (int s = 0; s < 8; s++)
         for (int o = 0; o < 16; o++)
            for (int a = 0; a < 4; a++)
               one(s, o, a);
   endtask

   initial begin
      int f, p, lat, ms, am, pk;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 req_ready", int'(req_ready), 1);
      chk("R1 rsp_valid", int'(rsp_valid), 0);
      chk("R1 mem_req_valid", int'(mem_req_valid), 0);
      xlate(0, 0, 0, f, p, lat, ms, am, pk);
      chk("R1 fault after reset", f, 1);

      cfg(0, 10); cfg(1, 5);
      sweep();
      cfg(0, 60); cfg(1, 8);
      sweep();
      cfg(1, 0);
      for (int s = 0; s < 8; s++) one(s, 1, 0);

      // R11: writes landing while a translation is held open
      cfg(0, 20); cfg(1, 8);
      @(negedge clk); stall = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; req_seg = 3'd2; req_off = '0; req_acc = 2'd0;
      @(negedge clk);
      req_valid = 1'b0;
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 6'd40;
      @(negedge clk);
      cfg_wdata = 6'd44;
      @(negedge clk);
      cfg_sel = 1'b1; cfg_wdata = 6'd1;
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R11 still held", int'(mem_req_valid), 1);
      stall = 1'b0;
      lat = 0;
      while (!rsp_valid && lat < 60) begin @(negedge clk); lat++; end
      chk("R11 old base used", last_addr, 22);
      begin
         int ef, ep, kind;
         model(2, 0, 0, ef, ep, kind);
         chk("R11 held answer fault", int'(rsp_fault), ef);
         chk("R11 held answer paddr", int'(rsp_paddr), ep);
      end
      @(negedge clk);
      mdl_base = 44; mdl_len = 1;
      xlate(0, 0, 0, f, p, lat, ms, am, pk);
      chk("R11 new base applied", last_addr, 44);
      xlate(2, 0, 0, f, p, lat, ms, am, pk);
      chk("R11 new length applied", f, 1);

      summary();
   end

endmodule